// File: doc/BRIEF.md
# System Interrupt Pending and Mask Register File

This block is the system-wide half of a multi-processor interrupt controller. It watches a vector of level-sensitive interrupt source lines and keeps, for every source, a pending flag and a disable flag. It also holds the index of the processor that currently receives system interrupts. A small word-addressed register bus lets software read the pending and disable state, enable or disable sources through separate clear and set registers, and choose the target processor.

Each source line has a fixed priority level, chosen at build time. A source with level zero is unmapped and has no effect. When a mapped source rises, its pending flag is set. When it falls, the flag is cleared. In the same edge, a one-cycle event tells the per-processor blocks which level bit to set or clear for the current target processor. Bit 31 of the disable register is a master switch. While it is set, nothing is routed. The block presents the raw pending, disable and target state to a downstream router, together with the masked pending vector and the bitmap of the levels that vector would raise.

Reset is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `sysint_master_regs`

## Requirements
- R1: After reset the pending register is 0 and the target index is 0. The disable register holds 0x0FA2007F: every reserved bit is set and every writable bit is clear, so a read of index 1 returns 0. Reserved bits stay set for ever, so those sources never route.
- R2: The register index is bus_addr[4:2], and bus_addr[1:0] is ignored. A read of index 0 returns the pending register with bit 31 forced to 0.
- R3: A read of index 1 returns the disable register ANDed with the writable mask 0xF05DFF80.
- R4: A write to index 2 clears, at the next clock edge, the disable bits that are set in the write data and also in 0xF05DFF80. This enables those sources.
- R5: A write to index 3 sets, at the next clock edge, the disable bits that are set in the write data and also in 0xF05DFF80. At the same edge it clears the same pending bits. If a source rises in that same cycle on a bit being written, the write wins and the pending bit stays clear.
- R6: A write to index 4 stores bus_wdata[3:0] as the target index. A read of index 4 returns the target index in bits [3:0], with zeros above.
- R7: Reads of indices 5 to 7 return 0, and writes to them change nothing. bus_rdata is 0 whenever no read is requested (bus_req low or bus_wr high).
- R8: Source j has level 0 for j < 4 and level ((j-4) mod 15)+1 otherwise. Transitions on a level-0 source are ignored, so its pending bit stays 0.
- R9: A rising transition on a mapped source sets its pending bit at the clock edge where it is first sampled high. A falling transition clears the bit at the edge where it is first sampled low.
- R10: route_vec equals pending AND NOT disable, and it is all zero while disable bit 31 is set. Bit l of route_lvl is set exactly when some source of level l (l ≥ 1) is set in route_vec.
- R11: For one cycle after the edge that samples source transitions, lvl_set has a 1 at the level of every mapped rising source, and lvl_clr has a 1 at the level of every mapped falling source whose level is not also in lvl_set. lvl_cpu carries the target index that was in force before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 32 | Level-sensitive interrupt source lines |
| bus_req | input | 1 | Register bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address in the 0x14-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and state |
| pend_o | output | 32 | Raw pending register |
| dis_o | output | 32 | Raw disable register |
| tgt_o | output | 4 | Target processor index |
| route_vec | output | 32 | Pending sources that may be routed |
| route_lvl | output | 16 | Bitmap of levels raised by route_vec |
| lvl_set | output | 16 | One-cycle level bits to set in the target processor |
| lvl_clr | output | 16 | One-cycle level bits to clear in the target processor |
| lvl_cpu | output | 4 | Processor that lvl_set and lvl_clr address |

## Verification
The checker watches several rules on every cycle:
- the reserved disable bits stay set;
- level-0 sources never become pending;
- idle read data is zero, and bit 31 is zero in pending readback;
- after each enable, disable or target write, the register state on the next cycle matches the write;
- the master disable silences route_lvl;
- the level set and clear events never overlap.

Other behaviour only shows up in the bench's scenarios, which compare every output against a model of the register file:
- the exact pending contents after mixed rising and falling sources;
- a disable write racing a source edge on the same bit;
- set-over-clear when two sources share a level;
- writes to unused indices or with unaligned addresses.

// File: rtl/sysint_pkg.sv
package sysint_pkg;

  localparam int DATA_W   = 32;
  localparam int IDX_W    = 3;
  localparam int MDIS_BIT = 31;

  // bits that software can never change in the disable register
  localparam logic [DATA_W-1:0] RSV_MASK = 32'h0FA2_007F;
  localparam logic [DATA_W-1:0] WR_MASK  = ~RSV_MASK;

  typedef enum logic [IDX_W-1:0] {
    IX_PEND = 3'd0,
    IX_DIS  = 3'd1,
    IX_ENA  = 3'd2,
    IX_DSET = 3'd3,
    IX_TGT  = 3'd4
  } reg_ix_e;

  typedef struct packed {
    logic              rd;
    logic              wr;
    logic [IDX_W-1:0]  ix;
    logic [DATA_W-1:0] data;
  } bus_op_t;

  // default level map: sources 0..3 unmapped, the rest cycle through 1..15
  function automatic logic [32*4-1:0] default_level_map();
    logic [32*4-1:0] m;
    m = '0;
    for (int j = 0; j < 32; j++) begin
      if (j >= 4) m[j*4 +: 4] = 4'((j - 4) % 15 + 1);
    end
    return m;
  endfunction

endpackage

// File: rtl/sysint_src_track.sv
module sysint_src_track
  import sysint_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int LVL_W = 4,
  parameter int CPU_W = 4,
  parameter logic [NSRC*LVL_W-1:0] LVL_MAP = default_level_map()
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          src_i,
  input  logic [CPU_W-1:0]         tgt_i,
  output logic [NSRC-1:0]          rise_o,
  output logic [NSRC-1:0]          fall_o,
  output logic [(1<<LVL_W)-1:0]    lvl_set_o,
  output logic [(1<<LVL_W)-1:0]    lvl_clr_o,
  output logic [CPU_W-1:0]         lvl_cpu_o
);

  localparam int NUM_LVL = 1 << LVL_W;

  logic [NSRC-1:0]    src_q;
  logic [NSRC-1:0]    mapped;
  logic [NUM_LVL-1:0] set_d, clr_d, set_q, clr_q;
  logic [CPU_W-1:0]   cpu_q;

  for (genvar j = 0; j < NSRC; j++) begin : g_map
    assign mapped[j] = |LVL_MAP[j*LVL_W +: LVL_W];
  end

  assign rise_o = src_i & ~src_q & mapped;
  assign fall_o = ~src_i & src_q & mapped;

  // next-state: translate source transitions into level events
  always_comb begin
    set_d = '0;
    clr_d = '0;
    for (int j = 0; j < NSRC; j++) begin
      if (rise_o[j]) set_d[LVL_MAP[j*LVL_W +: LVL_W]] = 1'b1;
      if (fall_o[j]) clr_d[LVL_MAP[j*LVL_W +: LVL_W]] = 1'b1;
    end
    clr_d = clr_d & ~set_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      set_q <= '0;
      clr_q <= '0;
      cpu_q <= '0;
    end else begin
      src_q <= src_i;
      set_q <= set_d;
      clr_q <= clr_d;
      cpu_q <= tgt_i;
    end
  end

  assign lvl_set_o = set_q;
  assign lvl_clr_o = clr_q;
  assign lvl_cpu_o = cpu_q;

endmodule

// File: rtl/sysint_reg_core.sv
module sysint_reg_core
  import sysint_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int CPU_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bus_op_t          op_i,
  input  logic [NSRC-1:0]  rise_i,
  input  logic [NSRC-1:0]  fall_i,
  output logic [NSRC-1:0]  pend_o,
  output logic [NSRC-1:0]  dis_o,
  output logic [CPU_W-1:0] tgt_o
);

  logic [NSRC-1:0]  pend_q, pend_d;
  logic [NSRC-1:0]  dis_q, dis_d;
  logic [CPU_W-1:0] tgt_q, tgt_d;
  logic             pend_en, dis_en, tgt_en;
  logic [NSRC-1:0]  wmask;

  assign wmask = op_i.data[NSRC-1:0] & WR_MASK[NSRC-1:0];

  always_comb begin
    pend_d  = (pend_q | rise_i) & ~fall_i;
    dis_d   = dis_q;
    tgt_d   = tgt_q;
    dis_en  = 1'b0;
    tgt_en  = 1'b0;
    if (op_i.wr) begin
      unique case (op_i.ix)
        IX_ENA: begin
          dis_d  = dis_q & ~wmask;
          dis_en = 1'b1;
        end
        IX_DSET: begin
          dis_d  = dis_q | wmask;
          dis_en = 1'b1;
          pend_d = pend_d & ~wmask;
        end
        IX_TGT: begin
          tgt_d  = op_i.data[CPU_W-1:0];
          tgt_en = 1'b1;
        end
        default: ;
      endcase
    end
    pend_en = (pend_d != pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      dis_q  <= RSV_MASK[NSRC-1:0];
      tgt_q  <= '0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (dis_en)  dis_q  <= dis_d;
      if (tgt_en)  tgt_q  <= tgt_d;
    end
  end

  assign pend_o = pend_q;
  assign dis_o  = dis_q;
  assign tgt_o  = tgt_q;

endmodule

// File: rtl/sysint_route.sv
module sysint_route
  import sysint_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int LVL_W = 4,
  parameter logic [NSRC*LVL_W-1:0] LVL_MAP = default_level_map()
) (
  input  logic [NSRC-1:0]       pend_i,
  input  logic [NSRC-1:0]       dis_i,
  output logic [NSRC-1:0]       route_o,
  output logic [(1<<LVL_W)-1:0] lvl_o
);

  localparam int NUM_LVL = 1 << LVL_W;

  assign route_o = dis_i[MDIS_BIT] ? '0 : (pend_i & ~dis_i);

  assign lvl_o[0] = 1'b0;
  for (genvar l = 1; l < NUM_LVL; l++) begin : g_lvl
    logic [NSRC-1:0] hit;
    for (genvar j = 0; j < NSRC; j++) begin : g_src
      assign hit[j] = route_o[j] && (LVL_MAP[j*LVL_W +: LVL_W] == LVL_W'(l));
    end
    assign lvl_o[l] = |hit;
  end

endmodule

// File: rtl/sysint_rd_mux.sv
module sysint_rd_mux
  import sysint_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int CPU_W = 4
) (
  input  bus_op_t            op_i,
  input  logic [NSRC-1:0]    pend_i,
  input  logic [NSRC-1:0]    dis_i,
  input  logic [CPU_W-1:0]   tgt_i,
  output logic [DATA_W-1:0]  rdata_o
);

  logic [DATA_W-1:0] pend_w, dis_w;

  always_comb begin
    pend_w           = DATA_W'(pend_i);
    pend_w[MDIS_BIT] = 1'b0;
    dis_w            = DATA_W'(dis_i) & WR_MASK;
  end

  always_comb begin
    rdata_o = '0;
    if (op_i.rd) begin
      unique case (op_i.ix)
        IX_PEND: rdata_o = pend_w;
        IX_DIS:  rdata_o = dis_w;
        IX_TGT:  rdata_o = DATA_W'(tgt_i);
        default: rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/sysint_master_regs.sv
module sysint_master_regs
  import sysint_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int LVL_W  = 4,
  parameter int CPU_W  = 4,
  parameter int ADDR_W = 5,
  parameter logic [NSRC*LVL_W-1:0] LVL_MAP = default_level_map()
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         src_irq,
  input  logic                    bus_req,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic [NSRC-1:0]         pend_o,
  output logic [NSRC-1:0]         dis_o,
  output logic [CPU_W-1:0]        tgt_o,
  output logic [NSRC-1:0]         route_vec,
  output logic [(1<<LVL_W)-1:0]   route_lvl,
  output logic [(1<<LVL_W)-1:0]   lvl_set,
  output logic [(1<<LVL_W)-1:0]   lvl_clr,
  output logic [CPU_W-1:0]        lvl_cpu
);

  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  bus_op_t         op;
  logic [NSRC-1:0] rise, fall;
  logic            unused_addr_lsb;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    op.rd   = bus_req & ~bus_wr;
    op.wr   = bus_req & bus_wr;
    op.ix   = bus_addr[ADDR_W-1:2];
    op.data = bus_wdata;
  end
  assign unused_addr_lsb = ^bus_addr[1:0];

  sysint_src_track #(
    .NSRC(NSRC), .LVL_W(LVL_W), .CPU_W(CPU_W), .LVL_MAP(LVL_MAP)
  ) u_src (
    .clk(clk), .rst_n(rst_sync_n), .src_i(src_irq), .tgt_i(tgt_o),
    .rise_o(rise), .fall_o(fall),
    .lvl_set_o(lvl_set), .lvl_clr_o(lvl_clr), .lvl_cpu_o(lvl_cpu)
  );

  sysint_reg_core #(.NSRC(NSRC), .CPU_W(CPU_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .op_i(op), .rise_i(rise), .fall_i(fall),
    .pend_o(pend_o), .dis_o(dis_o), .tgt_o(tgt_o)
  );

  sysint_route #(.NSRC(NSRC), .LVL_W(LVL_W), .LVL_MAP(LVL_MAP)) u_route (
    .pend_i(pend_o), .dis_i(dis_o), .route_o(route_vec), .lvl_o(route_lvl)
  );

  sysint_rd_mux #(.NSRC(NSRC), .CPU_W(CPU_W)) u_rd (
    .op_i(op), .pend_i(pend_o), .dis_i(dis_o), .tgt_i(tgt_o), .rdata_o(bus_rdata)
  );

endmodule

// File: rtl/sysint_master_regs_chk.sv
module sysint_master_regs_chk
  import sysint_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int LVL_W  = 4,
  parameter int CPU_W  = 4,
  parameter int ADDR_W = 5,
  parameter logic [NSRC*LVL_W-1:0] LVL_MAP = default_level_map()
) (
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic                  bus_req,
  input logic                  bus_wr,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic [NSRC-1:0]       pend_o,
  input logic [NSRC-1:0]       dis_o,
  input logic [CPU_W-1:0]      tgt_o,
  input logic [(1<<LVL_W)-1:0] route_lvl,
  input logic [(1<<LVL_W)-1:0] lvl_set,
  input logic [(1<<LVL_W)-1:0] lvl_clr
);

  logic [NSRC-1:0]  nz;
  logic [IDX_W-1:0] ix;
  logic             wr_ena, wr_dset, wr_tgt, rd_any;

  always_comb begin
    for (int j = 0; j < NSRC; j++) nz[j] = |LVL_MAP[j*LVL_W +: LVL_W];
  end
  assign ix      = bus_addr[ADDR_W-1:2];
  assign wr_ena  = bus_req && bus_wr && ix == IX_ENA;
  assign wr_dset = bus_req && bus_wr && ix == IX_DSET;
  assign wr_tgt  = bus_req && bus_wr && ix == IX_TGT;
  assign rd_any  = bus_req && !bus_wr;

  // R1
  rsv_dis_kept_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dis_o & RSV_MASK) == RSV_MASK);

  // R2
  pend_rd_b31_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_any && ix == IX_PEND) |-> !bus_rdata[MDIS_BIT]);

  // R4
  ena_wr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_ena |=> (dis_o & $past(bus_wdata & WR_MASK)) == '0);

  // R5
  dset_wr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_dset |=> ((dis_o & $past(bus_wdata & WR_MASK)) == $past(bus_wdata & WR_MASK))
             && ((pend_o & $past(bus_wdata & WR_MASK)) == '0));

  // R6
  tgt_wr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_tgt |=> tgt_o == $past(bus_wdata[CPU_W-1:0]));

  // R7
  idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_any |-> bus_rdata == '0);

  // R8
  unmapped_pend_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pend_o & ~nz) == '0);

  // R10
  mdis_route_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dis_o[MDIS_BIT] |-> route_lvl == '0);

  // R11
  lvl_evt_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((lvl_set & lvl_clr) == '0) && !lvl_set[0] && !lvl_clr[0]);

endmodule

bind sysint_master_regs sysint_master_regs_chk #(
  .NSRC(NSRC), .LVL_W(LVL_W), .CPU_W(CPU_W), .ADDR_W(ADDR_W), .LVL_MAP(LVL_MAP)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .bus_req(bus_req), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pend_o(pend_o), .dis_o(dis_o), .tgt_o(tgt_o), .route_lvl(route_lvl),
  .lvl_set(lvl_set), .lvl_clr(lvl_clr)
);

// File: tb/tb_sysint_master_regs.sv
`timescale 1ns/1ps
module tb_sysint_master_regs;

  localparam logic [31:0] RSV = 32'h0FA2_007F;
  localparam logic [31:0] WRM = 32'hF05D_FF80;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_irq;
  logic        bus_req, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, pend_o, dis_o, route_vec;
  logic [3:0]  tgt_o, lvl_cpu;
  logic [15:0] route_lvl, lvl_set, lvl_clr;

  always #2.5 clk = ~clk;

  sysint_master_regs dut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend_o(pend_o), .dis_o(dis_o), .tgt_o(tgt_o), .route_vec(route_vec),
    .route_lvl(route_lvl), .lvl_set(lvl_set), .lvl_clr(lvl_clr), .lvl_cpu(lvl_cpu)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_pend, m_dis, m_prev;
  logic [3:0]  m_tgt, e_cpu;
  logic [15:0] e_set, e_clr;

  function automatic int lvl_of(int j);
    return (j < 4) ? 0 : ((j - 4) % 15) + 1;
  endfunction

  function automatic logic [31:0] nz_mask();
    logic [31:0] m = '0;
    for (int j = 0; j < 32; j++) m[j] = (lvl_of(j) != 0);
    return m;
  endfunction

  function automatic logic [31:0] exp_route();
    return m_dis[31] ? 32'h0 : (m_pend & ~m_dis);
  endfunction

  function automatic logic [15:0] exp_rlvl(logic [31:0] rv);
    logic [15:0] b = '0;
    for (int j = 0; j < 32; j++) if (rv[j] && lvl_of(j) != 0) b[lvl_of(j)] = 1'b1;
    return b;
  endfunction

  function automatic logic [31:0] exp_read(logic rq, logic w, logic [4:0] a);
    if (!rq || w) return 32'h0;
    case (a[4:2])
      3'd0: return m_pend & 32'h7FFF_FFFF;
      3'd1: return m_dis & WRM;
      3'd4: return {28'h0, m_tgt};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] s, input logic rq, input logic w,
                      input logic [4:0] a, input logic [31:0] d);
    logic [31:0] rise, fall, wm, np, rv;
    logic [15:0] st, cl;
    string rtag;
    @(negedge clk);
    // registered level events from the previous edge (R11)
    chk(lvl_set == e_set, "R11 lvl_set", 32'(lvl_set), 32'(e_set));
    chk(lvl_clr == e_clr, "R11 lvl_clr", 32'(lvl_clr), 32'(e_clr));
    chk(lvl_cpu == e_cpu, "R11 lvl_cpu", 32'(lvl_cpu), 32'(e_cpu));
    src_irq = s; bus_req = rq; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    if (!rq || w) rtag = "R7 idle";
    else case (a[4:2])
      3'd0: rtag = "R2 pend read";
      3'd1: rtag = "R3 dis read";
      3'd4: rtag = "R6 tgt read";
      default: rtag = "R7 unused read";
    endcase
    chk(bus_rdata == exp_read(rq, w, a), rtag, bus_rdata, exp_read(rq, w, a));
    chk(pend_o == m_pend, "R9 pending", pend_o, m_pend);
    chk(dis_o == m_dis, "R4/R5 disable", dis_o, m_dis);
    chk(tgt_o == m_tgt, "R6 target", 32'(tgt_o), 32'(m_tgt));
    rv = exp_route();
    chk(route_vec == rv, "R10 route_vec", route_vec, rv);
    chk(route_lvl == exp_rlvl(rv), "R10 route_lvl", 32'(route_lvl), 32'(exp_rlvl(rv)));
    @(posedge clk);
    // model update for this edge
    rise = s & ~m_prev & nz_mask();
    fall = ~s & m_prev & nz_mask();
    st = '0; cl = '0;
    for (int j = 0; j < 32; j++) begin
      if (rise[j]) st[lvl_of(j)] = 1'b1;
      if (fall[j]) cl[lvl_of(j)] = 1'b1;
    end
    e_set = st; e_clr = cl & ~st; e_cpu = m_tgt;
    np = (m_pend | rise) & ~fall;
    wm = d & WRM;
    if (rq && w) begin
      case (a[4:2])
        3'd2: m_dis = m_dis & ~wm;
        3'd3: begin m_dis = m_dis | wm; np = np & ~wm; end
        3'd4: m_tgt = d[3:0];
        default: ;
      endcase
    end
    m_pend = np;
    m_prev = s;
  endtask

  task automatic wr(input logic [31:0] s, input logic [4:0] a, input logic [31:0] d);
    step(s, 1'b1, 1'b1, a, d);
  endtask

  task automatic rd(input logic [31:0] s, input logic [4:0] a);
    step(s, 1'b1, 1'b0, a, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    void'($urandom(32'd2718));
    rst_n = 1'b0; src_irq = '0; bus_req = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    m_pend = '0; m_dis = RSV; m_tgt = '0; m_prev = '0;
    e_set = '0; e_clr = '0; e_cpu = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state through readback and raw ports
    @(negedge clk);
    chk(dis_o == RSV, "R1 reset disable", dis_o, RSV);
    chk(pend_o == 0, "R1 reset pending", pend_o, 0);
    chk(tgt_o == 0, "R1 reset target", 32'(tgt_o), 0);
    rd(0, 5'h04); rd(0, 5'h00); rd(0, 5'h10);

    // R1/R4: enabling everything leaves reserved bits disabled
    wr(0, 5'h08, 32'hFFFF_FFFF);
    rd(0, 5'h04);
    // R8/R9: map all sources high, then reserved ones never route
    s = 32'hFFFF_FFFF;
    step(s, 0, 0, 0, 0);
    rd(s, 5'h00);
    // R10: master disable blocks routing, clearing it restores
    wr(s, 5'h0C, 32'h8000_0000);
    step(s, 0, 0, 0, 0);
    wr(s, 5'h08, 32'h8000_0000);
    step(s, 0, 0, 0, 0);
    // R9: all fall
    s = 0; step(s, 0, 0, 0, 0); step(s, 0, 0, 0, 0);

    // R5: disable-set write racing a rise on the same bit
    wr(32'h0000_0100, 5'h0C, 32'h0000_0100);
    rd(32'h0000_0100, 5'h00);
    wr(32'h0000_0100, 5'h08, 32'h0000_0100);
    step(0, 0, 0, 0, 0);

    // R11: bit 5 and bit 20 share level 2; rise 20 while 5 falls -> set wins
    step(32'h0000_0020, 0, 0, 0, 0);
    step(32'h0010_0000, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    // R6: target keeps low 4 bits; R7: unused index and unaligned address
    wr(0, 5'h13, 32'hFFFF_FFF9);
    rd(0, 5'h11);
    wr(0, 5'h14, 32'hFFFF_FFFF);
    wr(0, 5'h1C, 32'hFFFF_FFFF);
    rd(0, 5'h18); rd(0, 5'h05); rd(0, 5'h12);

    // constrained random mix
    s = 0;
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [4:0]  a;
      logic [31:0] d;
      s = s ^ ($urandom & $urandom & $urandom);
      r = $urandom % 10;
      a = 5'($urandom);
      d = $urandom;
      case (r)
        0, 1, 2, 3: rd(s, a);
        4: wr(s, 5'h08, d);
        5: wr(s, 5'h0C, (($urandom % 8) == 0) ? d : (d & 32'h7FFF_FFFF & $urandom));
        6: wr(s, 5'h10, d);
        7: wr(s, a, d & 32'h7FFF_FFFF);
        default: step(s, 1'b0, 1'($urandom), a, d);
      endcase
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule